// File: doc/BRIEF.md
# Sub-Register Aliased Register File

This block holds eight 32-bit registers for an execution core: four general-purpose registers (accumulator, base, count, data), two index registers and two pointer registers. Every register can be accessed as a full 32-bit value or through its low 16 bits. The four general registers also expose bits 15:8 and bits 7:0 as separate byte-sized registers. A partial write changes only the slice it addresses and leaves all other bits as they were.

There are two independent combinational read ports and one sized write port. Each port carries a register number and a size code. A second, paired write port loads the data register and the accumulator together in one cycle. Wide multiply and divide results need this, because they land in both registers at once.

A read returns the selected slice zero-extended to 32 bits. When a read addresses a register that is being written in the same cycle, it returns the value the register will hold after the clock edge. A byte-sized write aimed at an index or pointer register is flagged as illegal and writes nothing.

Top module: `alias_regfile`

## Requirements
- R1: A clock edge with `rst` high sets all eight registers to zero. The reset is synchronous.
- R2: Register numbers are 0 accumulator, 1 base, 2 count, 3 data, 4 source index, 5 destination index, 6 stack pointer and 7 base pointer. Size code 0 (dword) writes all 32 bits and reads all 32 bits.
- R3: Size code 1 (word) writes bits 15:0 from data bits 15:0 and keeps bits 31:16. A word read returns bits 15:0 with bits 31:16 of the output at zero.
- R4: Size code 2 (high byte) on registers 0 to 3 writes data bits 7:0 into register bits 15:8 and keeps every other bit. A high-byte read returns register bits 15:8 on output bits 7:0, with the rest of the output at zero.
- R5: Size code 3 (low byte) on registers 0 to 3 writes data bits 7:0 into register bits 7:0 and keeps every other bit. A low-byte read returns bits 7:0, zero-extended.
- R6: A write with size code 2 or 3 to a register numbered 4 to 7 raises `wr_illegal` in that cycle and leaves the register unchanged.
- R7: A read with size code 2 or 3 of a register numbered 4 to 7 returns zero.
- R8: When `pair_en` is high, the next clock edge loads `pair_hi_data` into register 3 and `pair_lo_data` into register 0. For those two registers the pair port takes priority over the ordinary write port. An ordinary write to any other register in the same cycle still takes effect.
- R9: A read that addresses a register being written in the same cycle returns the merged value that the register will hold after the edge. This applies to both the ordinary write port and the pair port.
- R10: The two read ports decode their register numbers and sizes independently, so they can read different registers and slices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Ordinary write enable |
| wr_reg | input | 3 | Register number for the write |
| wr_size | input | 2 | Size code for the write |
| wr_data | input | 32 | Write data, right-aligned |
| pair_en | input | 1 | Paired write enable |
| pair_hi_data | input | 32 | Value to load into the data register |
| pair_lo_data | input | 32 | Value to load into the accumulator |
| rd_reg_a | input | 3 | Register number for read port A |
| rd_size_a | input | 2 | Size code for read port A |
| rd_data_a | output | 32 | Read port A result, zero-extended |
| rd_reg_b | input | 3 | Register number for read port B |
| rd_size_b | input | 2 | Size code for read port B |
| rd_data_b | output | 32 | Read port B result, zero-extended |
| wr_illegal | output | 1 | Byte-size write to a register without byte aliases |

## Verification
The bench builds the block with its default parameters: 32-bit registers, 16-bit words, 8-bit bytes, eight registers of which four are general, and the pair mapped to registers 3 and 0. With these values the boundary between registers that have byte aliases and those that do not falls between registers 3 and 4, so byte accesses on both sides of it are exercised. The word and byte slices are narrow enough that each keep-the-other-bits case shows up directly in a single 32-bit pattern. The pair targets also coincide with registers that the ordinary port can address, which makes the same-cycle priority collision reachable.

// File: rtl/arf_pkg.sv
package arf_pkg;
   typedef enum logic [1:0] {
      SZ_DWORD = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_HIGH  = 2'd2,
      SZ_LOW   = 2'd3
   } access_size_e;
endpackage

// File: rtl/arf_slice_merge.sv
module arf_slice_merge #(
   parameter int DATA_W     = 32,
   parameter int WORD_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit ALLOW_BYTE = 1'b1
) (
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        size,
   input  logic              hit,
   output logic [DATA_W-1:0] new_val,
   output logic              illegal
);
   import arf_pkg::*;

   access_size_e sz;
   assign sz = access_size_e'(size);

   generate
      if (ALLOW_BYTE) begin : g_byte_lanes
         always_comb begin
            new_val = old_val;
            illegal = 1'b0;
            if (hit) begin
               case (sz)
                  SZ_DWORD: new_val = wr_data;
                  SZ_WORD:  new_val[WORD_W-1:0] = wr_data[WORD_W-1:0];
                  SZ_HIGH:  new_val[WORD_W-1:BYTE_W] = wr_data[BYTE_W-1:0];
                  default:  new_val[BYTE_W-1:0] = wr_data[BYTE_W-1:0];
               endcase
            end
         end
      end else begin : g_no_byte_lanes
         always_comb begin
            new_val = old_val;
            illegal = 1'b0;
            if (hit) begin
               case (sz)
                  SZ_DWORD: new_val = wr_data;
                  SZ_WORD:  new_val[WORD_W-1:0] = wr_data[WORD_W-1:0];
                  default:  illegal = 1'b1;
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/arf_read_port.sv
module arf_read_port #(
   parameter int DATA_W      = 32,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int NUM_REGS    = 8,
   parameter int NUM_GENERAL = 4,
   parameter int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic [DATA_W-1:0] regs [NUM_REGS],
   input  logic [IDX_W-1:0]  rd_reg,
   input  logic [1:0]        rd_size,
   output logic [DATA_W-1:0] rd_data
);
   import arf_pkg::*;

   logic [DATA_W-1:0] sel_val;
   logic              byte_ok;
   access_size_e      sz;

   assign sz      = access_size_e'(rd_size);
   assign byte_ok = ({1'b0, rd_reg} < (IDX_W+1)'(NUM_GENERAL));

   always_comb begin
      sel_val = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_reg == IDX_W'(k)) sel_val = regs[k];
      end
   end

   always_comb begin
      rd_data = '0;
      case (sz)
         SZ_DWORD: rd_data = sel_val;
         SZ_WORD:  rd_data[WORD_W-1:0] = sel_val[WORD_W-1:0];
         SZ_HIGH:  if (byte_ok) rd_data[BYTE_W-1:0] = sel_val[WORD_W-1:BYTE_W];
         default:  if (byte_ok) rd_data[BYTE_W-1:0] = sel_val[BYTE_W-1:0];
      endcase
   end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
   parameter int DATA_W      = 32,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int NUM_REGS    = 8,
   parameter int NUM_GENERAL = 4,
   parameter int ACC_IDX     = 0,
   parameter int DATA_IDX    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_reg,
   input  logic [1:0]        wr_size,
   input  logic [31:0]       wr_data,
   input  logic              pair_en,
   input  logic [31:0]       pair_hi_data,
   input  logic [31:0]       pair_lo_data,
   input  logic [2:0]        rd_reg_a,
   input  logic [1:0]        rd_size_a,
   output logic [31:0]       rd_data_a,
   input  logic [2:0]        rd_reg_b,
   input  logic [1:0]        rd_size_b,
   output logic [31:0]       rd_data_b,
   output logic              wr_illegal
);
   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (WORD_W != 2 * BYTE_W) begin : g_chk_word
         $error("WORD_W must be two bytes wide");
      end
      if (DATA_W < WORD_W || DATA_W != 32) begin : g_chk_data
         $error("DATA_W must be 32 and at least WORD_W");
      end
      if (NUM_REGS != 8 || NUM_GENERAL > NUM_REGS) begin : g_chk_regs
         $error("register count must be 8 with at most 8 general");
      end
      if (ACC_IDX >= NUM_GENERAL || DATA_IDX >= NUM_GENERAL || ACC_IDX == DATA_IDX) begin : g_chk_pair
         $error("pair registers must be distinct general registers");
      end
   endgenerate

   logic [DATA_W-1:0] regs_q      [NUM_REGS];
   logic [DATA_W-1:0] next_v      [NUM_REGS];
   logic [DATA_W-1:0] merged_v    [NUM_REGS];
   logic [NUM_REGS-1:0] illegal_v;
   logic [NUM_REGS-1:0] pair_hit_v;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         localparam bit BYTE_OK = (gi < NUM_GENERAL);
         localparam bit IS_PAIR = (gi == ACC_IDX) || (gi == DATA_IDX);
         logic hit;
         assign hit = wr_en && (wr_reg == IDX_W'(gi));

         arf_slice_merge #(
            .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .ALLOW_BYTE(BYTE_OK)
         ) u_merge (
            .old_val(regs_q[gi]),
            .wr_data(wr_data),
            .size(wr_size),
            .hit(hit),
            .new_val(merged_v[gi]),
            .illegal(illegal_v[gi])
         );

         if (IS_PAIR) begin : g_pair
            logic [DATA_W-1:0] pair_val;
            assign pair_val      = (gi == DATA_IDX) ? pair_hi_data : pair_lo_data;
            assign pair_hit_v[gi] = pair_en;
            assign next_v[gi]    = rst ? '0 : (pair_en ? pair_val : merged_v[gi]);
         end else begin : g_plain
            assign pair_hit_v[gi] = 1'b0;
            assign next_v[gi]    = rst ? '0 : merged_v[gi];
         end

         always_ff @(posedge clk) begin
            regs_q[gi] <= next_v[gi];
         end

         AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (regs_q[gi] == '0)); // R1

         AST_WORD_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
            (hit && wr_size == 2'd1 && !pair_hit_v[gi])
            |=> (regs_q[gi][DATA_W-1:WORD_W] == $past(regs_q[gi][DATA_W-1:WORD_W]))); // R3

         if (!BYTE_OK) begin : g_nobyte_chk
            AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
               (hit && wr_size[1]) |=> $stable(regs_q[gi])); // R6
         end
      end
   endgenerate

   assign wr_illegal = |illegal_v;

   arf_read_port #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
      .NUM_REGS(NUM_REGS), .NUM_GENERAL(NUM_GENERAL), .IDX_W(IDX_W)
   ) u_rd_a (
      .regs(next_v), .rd_reg(rd_reg_a), .rd_size(rd_size_a), .rd_data(rd_data_a)
   );

   arf_read_port #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
      .NUM_REGS(NUM_REGS), .NUM_GENERAL(NUM_GENERAL), .IDX_W(IDX_W)
   ) u_rd_b (
      .regs(next_v), .rd_reg(rd_reg_b), .rd_size(rd_size_b), .rd_data(rd_data_b)
   );

   AST_PAIR_BOTH: assert property (@(posedge clk) disable iff (rst)
      pair_en |=> (regs_q[DATA_IDX] == $past(pair_hi_data)
                   && regs_q[ACC_IDX] == $past(pair_lo_data))); // R8

   AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
      (rd_size_a != 2'd0) |-> (rd_data_a[DATA_W-1:WORD_W] == '0)); // R3

   AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_illegal && rd_reg_a == wr_reg && rd_size_a == 2'd0)
      |=> (regs_q[$past(rd_reg_a)] == $past(rd_data_a))); // R9

   AST_ILLEGAL_SRC: assert property (@(posedge clk) disable iff (rst)
      wr_illegal |-> (wr_en && wr_size[1] && wr_reg >= 3'(NUM_GENERAL))); // R6
endmodule

// File: tb/sim_alias_regfile.sv
`timescale 1ns/1ps
module sim_alias_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_reg = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] wr_data = '0;
   logic        pair_en = 1'b0;
   logic [31:0] pair_hi_data = '0;
   logic [31:0] pair_lo_data = '0;
   logic [2:0]  rd_reg_a = '0;
   logic [1:0]  rd_size_a = '0;
   logic [31:0] rd_data_a;
   logic [2:0]  rd_reg_b = '0;
   logic [1:0]  rd_size_b = '0;
   logic [31:0] rd_data_b;
   logic        wr_illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] model [8];
   logic [64:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   alias_regfile u0 (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_reg(wr_reg), .wr_size(wr_size), .wr_data(wr_data),
      .pair_en(pair_en), .pair_hi_data(pair_hi_data), .pair_lo_data(pair_lo_data),
      .rd_reg_a(rd_reg_a), .rd_size_a(rd_size_a), .rd_data_a(rd_data_a),
      .rd_reg_b(rd_reg_b), .rd_size_b(rd_size_b), .rd_data_b(rd_data_b),
      .wr_illegal(wr_illegal)
   );

   function automatic logic [31:0] ref_merge(logic [31:0] old, logic [31:0] d, logic [1:0] sz);
      logic [31:0] r = old;
      case (sz)
         2'd0: r = d;
         2'd1: r = {old[31:16], d[15:0]};
         2'd2: r = {old[31:16], d[7:0], old[7:0]};
         default: r = {old[31:8], d[7:0]};
      endcase
      return r;
   endfunction

   function automatic logic [31:0] ref_read(logic [31:0] v, logic [2:0] rg, logic [1:0] sz);
      case (sz)
         2'd0: return v;
         2'd1: return {16'h0, v[15:0]};
         2'd2: return (rg < 3'd4) ? {24'h0, v[15:8]} : 32'h0;
         default: return (rg < 3'd4) ? {24'h0, v[7:0]} : 32'h0;
      endcase
   endfunction

   task automatic cyc(input bit r, input bit we, input logic [2:0] wrg, input logic [1:0] ws,
                      input logic [31:0] wd, input bit pe, input logic [31:0] ph,
                      input logic [31:0] pl, input logic [2:0] ra, input logic [1:0] sa,
                      input logic [2:0] rb, input logic [1:0] sb, input string tag);
      logic [31:0] nxt [8];
      bit ill;
      @(posedge clk);
      #2;
      rst = r; wr_en = we; wr_reg = wrg; wr_size = ws; wr_data = wd;
      pair_en = pe; pair_hi_data = ph; pair_lo_data = pl;
      rd_reg_a = ra; rd_size_a = sa; rd_reg_b = rb; rd_size_b = sb;
      ill = we && ws[1] && (wrg >= 3'd4);
      for (int k = 0; k < 8; k++) nxt[k] = model[k];
      if (r) begin
         for (int k = 0; k < 8; k++) nxt[k] = 32'h0;
      end else begin
         if (we && !ill) nxt[wrg] = ref_merge(model[wrg], wd, ws);
         if (pe) begin
            nxt[3] = ph;
            nxt[0] = pl;
         end
      end
      exp_q.push_back({ill, ref_read(nxt[ra], ra, sa), ref_read(nxt[rb], rb, sb)});
      tag_q.push_back(tag);
      for (int k = 0; k < 8; k++) model[k] = nxt[k];
   endtask

   task automatic rd2(input logic [2:0] ra, input logic [1:0] sa,
                      input logic [2:0] rb, input logic [1:0] sb, input string tag);
      cyc(0, 0, 3'd0, 2'd0, 32'h0, 0, 32'h0, 32'h0, ra, sa, rb, sb, tag);
   endtask

   initial begin : monitor
      logic [64:0] e;
      string t;
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data_a !== e[63:32]) begin
               errors++;
               $display("FAIL %s port A: actual %h expected %h", t, rd_data_a, e[63:32]);
            end
            checks++;
            if (rd_data_b !== e[31:0]) begin
               errors++;
               $display("FAIL %s port B: actual %h expected %h", t, rd_data_b, e[31:0]);
            end
            checks++;
            if (wr_illegal !== e[64]) begin
               errors++;
               $display("FAIL %s wr_illegal: actual %b expected %b", t, wr_illegal, e[64]);
            end
         end
      end
   end

   initial begin : watchdog
      #3000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      for (int k = 0; k < 8; k++) model[k] = 32'hFFFF_FFFF;
      // R1: synchronous reset clears everything
      cyc(1, 1, 3'd2, 2'd0, 32'h1234_5678, 0, 0, 0, 3'd2, 2'd0, 3'd7, 2'd0, "R1 reset");
      cyc(1, 0, 3'd0, 2'd0, 32'h0, 0, 0, 0, 3'd0, 2'd0, 3'd5, 2'd0, "R1 reset");
      for (int k = 0; k < 8; k += 2)
         rd2(3'(k), 2'd0, 3'(k + 1), 2'd0, "R1 after reset");
      // R2 + R9: dword write, same-cycle bypass read
      cyc(0, 1, 3'd0, 2'd0, 32'h1122_3344, 0, 0, 0, 3'd0, 2'd0, 3'd1, 2'd0, "R2 R9 dword bypass");
      rd2(3'd0, 2'd0, 3'd0, 2'd1, "R2 dword readback");
      // R3 word write keeps upper half
      cyc(0, 1, 3'd0, 2'd1, 32'hAAAA_5555, 0, 0, 0, 3'd0, 2'd0, 3'd0, 2'd1, "R3 word write");
      // R4 high byte write
      cyc(0, 1, 3'd0, 2'd2, 32'hFFFF_FF77, 0, 0, 0, 3'd0, 2'd0, 3'd0, 2'd2, "R4 high byte write");
      // R5 low byte write
      cyc(0, 1, 3'd0, 2'd3, 32'hEEEE_EE99, 0, 0, 0, 3'd0, 2'd0, 3'd0, 2'd3, "R5 low byte write");
      rd2(3'd0, 2'd2, 3'd0, 2'd3, "R4 R5 byte reads");
      // R10: other general registers, different slices on each port
      cyc(0, 1, 3'd2, 2'd0, 32'hCAFE_F00D, 0, 0, 0, 3'd2, 2'd2, 3'd0, 2'd1, "R10 independent ports");
      rd2(3'd2, 2'd3, 3'd0, 2'd0, "R10 independent ports");
      // R6: index register, legal dword and word, illegal bytes
      cyc(0, 1, 3'd4, 2'd0, 32'h8765_4321, 0, 0, 0, 3'd4, 2'd0, 3'd4, 2'd1, "R2 index dword");
      cyc(0, 1, 3'd4, 2'd1, 32'h0000_BEEF, 0, 0, 0, 3'd4, 2'd0, 3'd4, 2'd1, "R3 index word");
      cyc(0, 1, 3'd4, 2'd2, 32'h0000_00AB, 0, 0, 0, 3'd4, 2'd0, 3'd2, 2'd0, "R6 illegal high byte");
      cyc(0, 1, 3'd7, 2'd3, 32'h0000_00CD, 0, 0, 0, 3'd7, 2'd0, 3'd4, 2'd0, "R6 illegal low byte");
      rd2(3'd4, 2'd0, 3'd7, 2'd0, "R6 unchanged after illegal");
      // R7: byte read of non-general registers returns zero
      cyc(0, 1, 3'd6, 2'd0, 32'h1357_9BDF, 0, 0, 0, 3'd6, 2'd2, 3'd6, 2'd3, "R7 byte read nongeneral");
      rd2(3'd6, 2'd1, 3'd4, 2'd3, "R7 byte read nongeneral");
      // R8: paired write with concurrent ordinary write elsewhere
      cyc(0, 1, 3'd1, 2'd0, 32'h0BAD_0BAD, 1, 32'hDEAD_BEEF, 32'h0102_0304,
          3'd3, 2'd0, 3'd0, 2'd0, "R8 R9 pair write bypass");
      rd2(3'd1, 2'd0, 3'd3, 2'd2, "R8 concurrent write kept");
      // R8: pair beats ordinary write to the accumulator
      cyc(0, 1, 3'd0, 2'd0, 32'h5555_5555, 1, 32'h0000_0011, 32'h0000_0022,
          3'd0, 2'd0, 3'd3, 2'd3, "R8 pair priority");
      cyc(0, 1, 3'd3, 2'd3, 32'h0000_00FF, 1, 32'hA0A0_A0A0, 32'h0B0B_0B0B,
          3'd3, 2'd0, 3'd0, 2'd1, "R8 pair priority data");
      rd2(3'd3, 2'd0, 3'd0, 2'd0, "R8 pair readback");
      // R1: reset mid-run
      cyc(1, 0, 3'd0, 2'd0, 32'h0, 0, 0, 0, 3'd3, 2'd0, 3'd6, 2'd0, "R1 mid-run reset");
      rd2(3'd4, 2'd0, 3'd1, 2'd0, "R1 mid-run reset");
      rd2(3'd2, 2'd0, 3'd7, 2'd0, "R1 mid-run reset");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule